// File: doc/BRIEF.md
# Codec Clock Qualification and ADC Start-up Sequencer

This block sits at the root of the digital side of an audio codec and decides when the converter paths may run. It is clocked by the master clock. The frame clock (one period per sample) and the bit clock are synchronous with it, but their phase against it is arbitrary. The block measures how many master-clock cycles make up each frame, which tells it whether the master clock runs at 256 or 384 times the sample rate. It also checks that the bit clock gives 32 rising edges per frame. Once two matching frames in a row are valid, the clocks are declared present. In the 384 case the block then issues a clock enable on two of every three master-clock cycles, so the downstream logic always advances at 256 times the sample rate.

The ADC, DAC and automatic-level-control paths are held in power-down until the clocks are present, whatever their enable inputs say. They fall back to power-down when the frame clock stops for too long, when a frame measures wrong, or when the active-low reset input is low. When the ADC path is released, a fixed number of frames must pass before its samples are trusted. During that settling window both ADC channel words are forced to two's-complement zero. The DAC path is never held back by this window. The settling count starts again from zero each time the ADC path is switched off and back on, including when the switch-off came from losing the clocks.

Top module: `codec_clk_seq`

## Requirements
- R1: A frame of exactly 256 master-clock cycles, with 32 bit-clock rising edges inside it, is valid in direct mode. In direct mode, once the clocks are present, `tick` is high on every master-clock cycle and `mode384` is low.
- R2: A frame of exactly 384 master-clock cycles, with 32 bit-clock rising edges, is valid in 2/3 mode. Once the clocks are present in this mode, `mode384` is high and `tick` repeats the pattern high, high, low, starting high in the first cycle after presence is declared.
- R3: A frame of any other length (for example 300 cycles) is invalid. It drops `clk_ok` at the frame edge that ends it.
- R4: `clk_ok` rises in the cycle after the second consecutive valid frame of the same mode has ended. The frame edge after reset only starts the first measurement. A change of mode between valid frames restarts qualification.
- R5: If 512 master-clock cycles pass without a frame-clock rising edge, `clk_ok` drops and qualification restarts from the next edge.
- R6: `adc_run`, `dac_run` and `alc_run` each equal `clk_ok` AND their own enable input, so all three stay low while the clocks are not present.
- R7: While `adc_run` is high, `settling` stays high until SETTLE_FRAMES frame-clock rising edges have been seen with `adc_run` high. During `settling`, and while `adc_run` is low, both ADC output words are zero. Otherwise they pass the inputs through unchanged.
- R8: `dac_run` is not delayed by the ADC settling window.
- R9: The settling count restarts from zero whenever `adc_run` goes low, whether from `adc_en` or from loss of the clocks.
- R10: While `pwr_rst_n` is low, all outputs are low and all state is cleared. After release, qualification starts from the beginning.
- R11: A frame whose bit-clock rising-edge count is not 32 is invalid, even when its length is correct.
- R12: The starting phase of the frame and bit clocks against the master clock does not change the results above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mst_clk | input | 1 | Master clock, 256 or 384 times the sample rate |
| pwr_rst_n | input | 1 | Asynchronous active-low reset of all state |
| frm_clk | input | 1 | Frame clock at the sample rate |
| bit_clk | input | 1 | Bit clock at 32 times the sample rate |
| adc_en | input | 1 | ADC path enable |
| dac_en | input | 1 | DAC path enable |
| alc_en | input | 1 | Automatic-level-control path enable |
| adc_l_in | input | W | Left ADC sample from the converter |
| adc_r_in | input | W | Right ADC sample from the converter |
| clk_ok | output | 1 | Clocks qualified as present |
| mode384 | output | 1 | Clocks present and master clock at 384 times the sample rate |
| tick | output | 1 | Clock enable giving an effective 256 times rate |
| adc_run | output | 1 | ADC path out of power-down |
| dac_run | output | 1 | DAC path out of power-down |
| alc_run | output | 1 | Automatic-level-control path out of power-down |
| settling | output | 1 | ADC settling window active |
| adc_l_out | output | W | Left ADC sample, zero when muted |
| adc_r_out | output | W | Right ADC sample, zero when muted |

## Verification
A wrong frame-length or bit-edge count shows up at the very frame edge where it is judged, as `clk_ok` going the wrong way one cycle later. A lost timeout shows up 512 cycles after the frame clock stops. A wrong phase in the 2/3 counter breaks the `tick` pattern within three cycles of presence. A settling counter that fails to restart, or ends one frame early or late, appears at the ports as non-zero ADC words in the wrong frame. Because of this, the bench compares every output against a reference model on every master-clock cycle. It walks through direct mode, 2/3 mode, a bad ratio, a silent bit clock, a stopped frame clock, ADC re-enable and a mid-run reset.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
   // classification of one completed frame
   typedef enum logic [1:0] {
      FK_BAD = 2'd0,
      FK_LO  = 2'd1,
      FK_HI  = 2'd2
   } frame_kind_e;
endpackage

// File: rtl/ccs_frame_meter.sv
module ccs_frame_meter
   import ccs_pkg::*;
#(
   parameter int RATIO_LO       = 256,
   parameter int RATIO_HI       = 384,
   parameter int BITS_PER_FRAME = 32,
   parameter int TIMEOUT        = 512,
   parameter bit ALLOW_HI       = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frm_clk,
   input  logic        bit_clk,
   output logic        frame_rise,
   output frame_kind_e kind,
   output logic        lost
);
   localparam int CW = $clog2(TIMEOUT + 1);
   localparam int BW = $clog2(BITS_PER_FRAME + 3);
   localparam logic [BW-1:0] BSAT = BW'(BITS_PER_FRAME + 1);

   logic          f_q, b_q, prev_q;
   logic [CW-1:0] cnt_q, meas;
   logic [BW-1:0] bc_q, bits;
   logic          brise, lo_hit, hi_hit, bits_ok;

   assign frame_rise = frm_clk & ~f_q;
   assign brise      = bit_clk & ~b_q;
   assign meas       = cnt_q + CW'(1);
   assign bits       = bc_q + BW'(brise);
   assign bits_ok    = (bits == BW'(BITS_PER_FRAME));
   assign lo_hit     = (meas == CW'(RATIO_LO));
   assign lost       = ~frame_rise & (cnt_q == CW'(TIMEOUT - 1));

   generate
      if (ALLOW_HI) begin : g_hi
         assign hi_hit = (meas == CW'(RATIO_HI));
      end else begin : g_no_hi
         assign hi_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      kind = FK_BAD;
      if (prev_q && bits_ok) begin
         if (lo_hit)      kind = FK_LO;
         else if (hi_hit) kind = FK_HI;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_q    <= 1'b0;
         b_q    <= 1'b0;
         prev_q <= 1'b0;
         cnt_q  <= '0;
         bc_q   <= '0;
      end else begin
         f_q <= frm_clk;
         b_q <= bit_clk;
         if (frame_rise) begin
            prev_q <= 1'b1;
            cnt_q  <= '0;
            bc_q   <= '0;
         end else if (lost) begin
            prev_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
            if (bc_q != BSAT) bc_q <= bits;
         end
      end
   end
endmodule

// File: rtl/ccs_qualifier.sv
module ccs_qualifier
   import ccs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frame_rise,
   input  frame_kind_e kind,
   input  logic        lost,
   output logic        clk_ok,
   output logic        mode_hi
);
   logic seen_q, ok_q, hi_q, kind_hi;

   assign kind_hi = (kind == FK_HI);
   assign clk_ok  = ok_q;
   assign mode_hi = hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         ok_q   <= 1'b0;
         hi_q   <= 1'b0;
      end else if (lost) begin
         seen_q <= 1'b0;
         ok_q   <= 1'b0;
      end else if (frame_rise) begin
         if (kind == FK_BAD) begin
            seen_q <= 1'b0;
            ok_q   <= 1'b0;
         end else if (seen_q && (hi_q == kind_hi)) begin
            ok_q <= 1'b1;
         end else begin
            seen_q <= 1'b1;
            hi_q   <= kind_hi;
            ok_q   <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ccs_rate_div.sv
module ccs_rate_div #(
   parameter bit ALLOW_HI = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_ok,
   input  logic mode_hi,
   output logic tick
);
   generate
      if (ALLOW_HI) begin : g_div3
         logic [1:0] ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                ph_q <= 2'd0;
            else if (clk_ok & mode_hi) ph_q <= (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
            else                       ph_q <= 2'd0;
         end
         assign tick = clk_ok & (~mode_hi | (ph_q != 2'd2));
      end else begin : g_direct
         assign tick = clk_ok & ~mode_hi;
      end
   endgenerate
endmodule

// File: rtl/ccs_settle.sv
module ccs_settle #(
   parameter int W             = 16,
   parameter int NCH           = 2,
   parameter int SETTLE_FRAMES = 4128
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  adc_run,
   input  logic                  frame_rise,
   input  logic [NCH-1:0][W-1:0] din,
   output logic [NCH-1:0][W-1:0] dout,
   output logic                  settling
);
   localparam int SW = $clog2(SETTLE_FRAMES + 1);
   localparam logic [SW-1:0] SLIM = SW'(SETTLE_FRAMES);

   logic [SW-1:0] sc_q;
   logic          pass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sc_q <= '0;
      else if (!adc_run)                   sc_q <= '0;
      else if (frame_rise && sc_q != SLIM) sc_q <= sc_q + SW'(1);
   end

   assign settling = adc_run & (sc_q != SLIM);
   assign pass     = adc_run & ~settling;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         assign dout[c] = pass ? din[c] : '0;
      end
   endgenerate
endmodule

// File: rtl/codec_clk_seq.sv
module codec_clk_seq
   import ccs_pkg::*;
#(
   parameter int W              = 16,
   parameter int RATIO_LO       = 256,
   parameter int RATIO_HI       = 384,
   parameter int BITS_PER_FRAME = 32,
   parameter int TIMEOUT        = 512,
   parameter int SETTLE_FRAMES  = 4128,
   parameter bit ALLOW_HI       = 1'b1
) (
   input  logic         mst_clk,
   input  logic         pwr_rst_n,
   input  logic         frm_clk,
   input  logic         bit_clk,
   input  logic         adc_en,
   input  logic         dac_en,
   input  logic         alc_en,
   input  logic [W-1:0] adc_l_in,
   input  logic [W-1:0] adc_r_in,
   output logic         clk_ok,
   output logic         mode384,
   output logic         tick,
   output logic         adc_run,
   output logic         dac_run,
   output logic         alc_run,
   output logic         settling,
   output logic [W-1:0] adc_l_out,
   output logic [W-1:0] adc_r_out
);
   localparam int NCH = 2;

   initial begin
      assert (W > 0);
      assert (RATIO_HI > RATIO_LO);
      assert (TIMEOUT > RATIO_HI);
      assert (SETTLE_FRAMES > 0);
      assert (BITS_PER_FRAME > 0);
   end

   logic        frame_rise, lost, mode_hi;
   frame_kind_e kind;
   logic [NCH-1:0][W-1:0] din, dout;

   ccs_frame_meter #(
      .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI), .BITS_PER_FRAME(BITS_PER_FRAME),
      .TIMEOUT(TIMEOUT), .ALLOW_HI(ALLOW_HI)
   ) meter_i (
      .clk(mst_clk), .rst_n(pwr_rst_n), .frm_clk(frm_clk), .bit_clk(bit_clk),
      .frame_rise(frame_rise), .kind(kind), .lost(lost)
   );

   ccs_qualifier qual_i (
      .clk(mst_clk), .rst_n(pwr_rst_n), .frame_rise(frame_rise), .kind(kind),
      .lost(lost), .clk_ok(clk_ok), .mode_hi(mode_hi)
   );

   ccs_rate_div #(.ALLOW_HI(ALLOW_HI)) div_i (
      .clk(mst_clk), .rst_n(pwr_rst_n), .clk_ok(clk_ok), .mode_hi(mode_hi), .tick(tick)
   );

   assign mode384 = clk_ok & mode_hi;
   assign adc_run = clk_ok & adc_en;
   assign dac_run = clk_ok & dac_en;
   assign alc_run = clk_ok & alc_en;

   assign din[0] = adc_l_in;
   assign din[1] = adc_r_in;

   ccs_settle #(.W(W), .NCH(NCH), .SETTLE_FRAMES(SETTLE_FRAMES)) settle_i (
      .clk(mst_clk), .rst_n(pwr_rst_n), .adc_run(adc_run), .frame_rise(frame_rise),
      .din(din), .dout(dout), .settling(settling)
   );

   assign adc_l_out = dout[0];
   assign adc_r_out = dout[1];
endmodule

// File: rtl/codec_clk_seq_chk.sv
module codec_clk_seq_chk #(
   parameter int W = 16
) (
   input logic         mst_clk,
   input logic         pwr_rst_n,
   input logic         frm_clk,
   input logic         dac_en,
   input logic         clk_ok,
   input logic         mode384,
   input logic         tick,
   input logic         adc_run,
   input logic         dac_run,
   input logic         alc_run,
   input logic         settling,
   input logic [W-1:0] adc_l_out,
   input logic [W-1:0] adc_r_out
);
   // R1
   direct_tick_chk: assert property (@(posedge mst_clk) disable iff (!pwr_rst_n)
      clk_ok && !mode384 |-> tick);

   // R2
   hi_pattern_chk: assert property (@(posedge mst_clk) disable iff (!pwr_rst_n)
      mode384 && $past(mode384) && $past(mode384, 2) |-> !(tick && $past(tick) && $past(tick, 2)));

   // R4
   ok_on_frame_chk: assert property (@(posedge mst_clk) disable iff (!pwr_rst_n)
      $rose(clk_ok) |-> $past(frm_clk) && !$past(frm_clk, 2));

   // R6
   gated_off_chk: assert property (@(posedge mst_clk) disable iff (!pwr_rst_n)
      !clk_ok |-> !adc_run && !dac_run && !alc_run);

   // R7
   muted_chk: assert property (@(posedge mst_clk) disable iff (!pwr_rst_n)
      settling |-> adc_run && adc_l_out == '0 && adc_r_out == '0);

   // R8
   dac_free_chk: assert property (@(posedge mst_clk) disable iff (!pwr_rst_n)
      clk_ok && dac_en |-> dac_run);
endmodule

bind codec_clk_seq codec_clk_seq_chk #(.W(W)) chk_i (.*);

// File: tb/codec_clk_seq_test.sv
module codec_clk_seq_test;
   localparam int W  = 16;
   localparam int S  = 5;
   localparam int TO = 512;

   logic mst_clk = 1'b0;
   always #4 mst_clk = ~mst_clk;

   logic pwr_rst_n, frm_clk, bit_clk, adc_en, dac_en, alc_en;
   logic [W-1:0] adc_l_in, adc_r_in, adc_l_out, adc_r_out;
   logic clk_ok, mode384, tick, adc_run, dac_run, alc_run, settling;

   codec_clk_seq #(.W(W), .SETTLE_FRAMES(S), .TIMEOUT(TO)) uut (.*);

   int total = 0, bad = 0, cyc = 0;
   string tag = "R10";

   // reference model state
   int m_cnt, m_bc, m_prev, m_seen, m_ok, m_hi, m_ph, m_sc, m_fq, m_bq;
   // stimulus generator
   int ratio = 256, p = 0;
   bit gen_on = 1, bclk_on = 1;

   task automatic chk(string what, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   function automatic void model_reset();
      m_cnt = 0; m_bc = 0; m_prev = 0; m_seen = 0; m_ok = 0;
      m_hi = 0; m_ph = 0; m_sc = 0; m_fq = 0; m_bq = 0;
   endfunction

   function automatic void model_step();
      int rise, brise, lost, meas, bits, k;
      int n_seen, n_ok, n_hi, n_ph, n_sc;
      rise  = (frm_clk && !m_fq) ? 1 : 0;
      brise = (bit_clk && !m_bq) ? 1 : 0;
      lost  = (!rise && m_cnt == TO - 1) ? 1 : 0;
      meas  = m_cnt + 1;
      bits  = m_bc + brise;
      k = 0;
      if (m_prev && bits == 32 && meas == 256) k = 1;
      else if (m_prev && bits == 32 && meas == 384) k = 2;
      n_seen = m_seen; n_ok = m_ok; n_hi = m_hi;
      if (lost) begin n_seen = 0; n_ok = 0; end
      else if (rise) begin
         if (k == 0) begin n_seen = 0; n_ok = 0; end
         else if (m_seen && m_hi == (k == 2)) n_ok = 1;
         else begin n_seen = 1; n_hi = (k == 2); n_ok = 0; end
      end
      n_ph = (m_ok && m_hi) ? (m_ph + 1) % 3 : 0;
      n_sc = m_sc;
      if (!(m_ok && adc_en)) n_sc = 0;
      else if (rise && m_sc < S) n_sc = m_sc + 1;
      if (rise) begin m_prev = 1; m_cnt = 0; m_bc = 0; end
      else if (lost) m_prev = 0;
      else begin m_cnt++; m_bc += brise; end
      m_seen = n_seen; m_ok = n_ok; m_hi = n_hi; m_ph = n_ph; m_sc = n_sc;
      m_fq = frm_clk; m_bq = bit_clk;
   endfunction

   task automatic compare();
      int e_adc, e_set, e_pass;
      e_adc  = m_ok && adc_en;
      e_set  = e_adc && (m_sc < S);
      e_pass = e_adc && !e_set;
      chk("clk_ok", clk_ok, m_ok);
      chk("mode384", mode384, m_ok && m_hi);
      chk("tick", tick, m_ok && (!m_hi || m_ph != 2));
      chk("adc_run", adc_run, e_adc);
      chk("dac_run", dac_run, m_ok && dac_en);
      chk("alc_run", alc_run, m_ok && alc_en);
      chk("settling", settling, e_set);
      chk("adc_l_out", adc_l_out, e_pass ? adc_l_in : 0);
      chk("adc_r_out", adc_r_out, e_pass ? adc_r_in : 0);
   endtask

   task automatic step();
      @(posedge mst_clk);
      if (pwr_rst_n) model_step();
      else model_reset();
      @(negedge mst_clk);
      cyc++;
      if (gen_on) begin
         p = (p + 1) % ratio;
         frm_clk = (p < ratio / 2);
         bit_clk = bclk_on && ((p % (ratio / 32)) < (ratio / 64));
      end else begin
         frm_clk = 1'b0;
         bit_clk = 1'b0;
      end
      adc_l_in = W'(cyc * 37 + 5);
      adc_r_in = ~W'(cyc);
      #1 compare();
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      repeat (150000) @(posedge mst_clk);
      total++; bad++;
      $display("FAIL %s watchdog expired actual=hung expected=finished", tag);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      pwr_rst_n = 1'b0; frm_clk = 1'b0; bit_clk = 1'b0;
      adc_en = 1'b0; dac_en = 1'b0; alc_en = 1'b0;
      adc_l_in = '0; adc_r_in = '0;
      model_reset();
      // R10: outputs held low in reset
      tag = "R10"; run(4);
      chk("clk_ok reset", clk_ok, 0);
      pwr_rst_n = 1'b1; adc_en = 1'b1; dac_en = 1'b1; alc_en = 1'b1;
      // R6: enables set, clocks not yet qualified
      tag = "R6"; run(300);
      chk("adc_run before presence", adc_run, 0);
      // R4: second valid frame declares presence
      tag = "R4"; run(256 * 2);
      // R1: direct mode, settling runs out
      tag = "R1"; run(256 * 8);
      chk("clk_ok direct", clk_ok, 1);
      chk("mode384 direct", mode384, 0);
      // R9: ADC re-enable restarts settling
      tag = "R9"; adc_en = 1'b0; run(600); adc_en = 1'b1; run(10);
      chk("settling restarted", settling, 1);
      // R8: DAC runs while ADC settles
      tag = "R8"; run(256 * 3);
      chk("dac_run during settling", dac_run, 1);
      chk("settling still on", settling, 1);
      // R7: settling ends, data passes
      tag = "R7"; run(256 * 4);
      chk("settling done", settling, 0);
      // R2 / R12: 384 mode starting at an odd phase
      tag = "R12"; ratio = 384; p = 101; run(384 * 3);
      tag = "R2"; run(384 * 6);
      chk("mode384 on", mode384, 1);
      // R3: unsupported ratio
      tag = "R3"; ratio = 300; p = 7; run(300 * 5);
      chk("clk_ok bad ratio", clk_ok, 0);
      // R11: correct length, silent bit clock
      tag = "R11"; ratio = 256; p = 33; bclk_on = 0; run(256 * 5);
      chk("clk_ok no bit clock", clk_ok, 0);
      bclk_on = 1; run(256 * 4);
      chk("clk_ok bit clock back", clk_ok, 1);
      // R5: frame clock stops
      tag = "R5"; gen_on = 0; run(700);
      chk("clk_ok lost", clk_ok, 0);
      chk("adc_run lost", adc_run, 0);
      // R9: recovery restarts settling from zero
      tag = "R9"; gen_on = 1; run(256 * 4);
      chk("settling after recovery", settling, 1);
      run(256 * 5);
      chk("settling over after recovery", settling, 0);
      // R10: reset in the middle of operation
      tag = "R10"; pwr_rst_n = 1'b0; model_reset(); #1 compare(); run(3);
      chk("clk_ok mid reset", clk_ok, 0);
      pwr_rst_n = 1'b1; run(256 * 4);
      chk("clk_ok after reset", clk_ok, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule